// File: doc/BRIEF.md
# Bit-Level Pipelined Ripple-Carry Adder

This block adds two unsigned W-bit operands and returns the (W+1)-bit sum. It is built as a ripple-carry chain, but every bit position is a separate registered stage. Each carry moves up one position per clock. Operand bits wait in a skew triangle until the carry from the position below reaches them. The finished sum bits then wait in a deskew triangle so that all of them leave in the same cycle.

Because every path from the inputs to a given stage crosses the same number of registers, a new operand pair can enter on every clock. Each result comes out a fixed W+1 cycles after its operands. A one-bit valid flag goes through the same number of stages, so the caller can insert bubbles at will.

Top module: `pipe_rca`

## Requirements
- R1: For every operand pair accepted with `in_vld` high, `sum` equals the unsigned value `a + b`, W+1 bits wide, with no carry-in.
- R2: An operand pair sampled at clock edge k appears on `sum` with `out_vld` high right after edge k+W, which is W+1 edges counting the sampling edge.
- R3: A new operand pair may be presented on every clock. Back-to-back pairs give back-to-back results in consecutive cycles, and each result is independent of its neighbours.
- R4: `out_vld` equals `in_vld` delayed by exactly W+1 cycles. A cycle presented with `in_vld` low never produces `out_vld` high.
- R5: Bit W of `sum` is the carry out of the top position. It is 1 exactly when a + b is at least 2^W.
- R6: While `rst_n` is low, `out_vld` and `sum` are both 0, whatever the inputs are.
- R7: A carry produced at bit 0 ripples through all W positions correctly. All-ones plus one gives exactly 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks `a` and `b` as a pair to add this cycle |
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| out_vld | output | 1 | Marks `sum` as a result |
| sum | output | W+1 | Unsigned sum, bit W being the final carry |

## Verification
A skew register that holds bit i one cycle too long or too short pairs that bit with the wrong carry. It then corrupts bit i and above of a result whose neighbour operands differ, which shows up W+1 cycles after the faulty pair enters. The bench feeds every operand pair back-to-back with W = 8, so any misalignment between adjacent pipeline slots changes the sum at the port. A broken carry link shows up only on a pair that propagates through it, and the exhaustive sweep includes every such pair. A valid chain of the wrong length shows up as `out_vld` in the wrong cycle around bubbles.

// File: rtl/pipe_rca.sv
module pipe_rca #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_vld,
  output logic [W:0]   sum
);

  // operand skew: level k holds bits above k, delayed k+1 cycles
  for (genvar k = 0; k < W - 1; k++) begin : lv
    logic [W-1:k+1] ra, rb;
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ra <= '0;
          rb <= '0;
        end else begin
          ra <= a[W-1:1];
          rb <= b[W-1:1];
        end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ra <= '0;
          rb <= '0;
        end else begin
          ra <= lv[k-1].ra[W-1:k+1];
          rb <= lv[k-1].rb[W-1:k+1];
        end
    end
  end

  // carry chain: one registered adder position per stage
  for (genvar i = 0; i < W; i++) begin : pos
    logic s, c, v;
    if (i == 0) begin : g_half
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          s <= 1'b0;
          c <= 1'b0;
          v <= 1'b0;
        end else begin
          s <= a[0] ^ b[0];
          c <= a[0] & b[0];
          v <= in_vld;
        end
    end else begin : g_full
      logic x, y, ci;
      assign x  = lv[i-1].ra[i];
      assign y  = lv[i-1].rb[i];
      assign ci = pos[i-1].c;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          s <= 1'b0;
          c <= 1'b0;
          v <= 1'b0;
        end else begin
          s <= x ^ y ^ ci;
          c <= (x & y) | (ci & (x ^ y));
          v <= pos[i-1].v;
        end
    end
  end

  // sum deskew: row j holds bits below j, aligned with position j
  for (genvar j = 1; j < W; j++) begin : dk
    logic [j-1:0] lo;
    if (j == 1) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) lo <= '0;
        else        lo <= pos[0].s;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) lo <= '0;
        else        lo <= {pos[j-1].s, dk[j-1].lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_vld <= 1'b0;
      sum     <= '0;
    end else begin
      out_vld <= pos[W-1].v;
      sum     <= {pos[W-1].c, pos[W-1].s, dk[W-1].lo};
    end

endmodule

// File: rtl/pipe_rca_chk.sv
module pipe_rca_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_vld,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         out_vld,
  input logic [W:0]   sum
);

  logic         m_v [W+1];
  logic [W:0]   m_s [W+1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k <= W; k++) begin
        m_v[k] <= 1'b0;
        m_s[k] <= '0;
      end
    end else begin
      m_v[0] <= in_vld;
      m_s[0] <= {1'b0, a} + {1'b0, b};
      for (int k = 1; k <= W; k++) begin
        m_v[k] <= m_v[k-1];
        m_s[k] <= m_s[k-1];
      end
    end

  // R4
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == m_v[W]);

  // R1
  sum_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> sum == m_s[W]);

  // R5
  top_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> sum[W] == m_s[W][W]);

  // R3
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_v[W] && m_v[W-1]) |=> (out_vld && sum == $past(m_s[W-1])));

  // R6
  always @(negedge clk)
    if (!rst_n) reset_state_chk: assert (!out_vld && sum == '0);

endmodule

bind pipe_rca pipe_rca_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b),
  .out_vld(out_vld), .sum(sum)
);

// File: tb/tb_pipe_rca.sv
module tb_pipe_rca;
  localparam int W       = 8;
  localparam int LAT     = W + 1;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_vld;
  logic [W-1:0] a, b;
  logic         out_vld;
  logic [W:0]   sum;

  pipe_rca #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b),
    .out_vld(out_vld), .sum(sum)
  );

  always #(CLK_PER/2) clk = ~clk;

  int         total = 0;
  int         bad   = 0;
  int         cyc   = 0;
  bit         done  = 1'b0;
  logic       rv [32];
  logic [W:0] rs [32];
  int         rt [32];

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] x, input logic [W-1:0] y,
                      input int tag);
    int idx;
    @(negedge clk);
    if (cyc >= LAT) begin
      idx = (cyc - LAT) % 32;
      chk("R4", {{W{1'b0}}, out_vld}, {{W{1'b0}}, rv[idx]});
      if (rv[idx]) begin
        if (rt[idx] == 0)      chk("R1 R3", sum, rs[idx]);
        else if (rt[idx] == 1) chk("R2", sum, rs[idx]);
        else begin
          chk("R7", sum, rs[idx]);
          chk("R5", {{W{1'b0}}, sum[W]}, {{W{1'b0}}, rs[idx][W]});
        end
      end
    end else begin
      chk("R4", {{W{1'b0}}, out_vld}, '0);
    end
    in_vld = v;
    a = x;
    b = y;
    rv[cyc % 32] = v;
    rs[cyc % 32] = {1'b0, x} + {1'b0, y};
    rt[cyc % 32] = tag;
    cyc++;
  endtask

  task automatic corner(input logic [W-1:0] x, input logic [W-1:0] y);
    step(1'b1, x, y, 2);
    step(1'b0, ~x, ~y, 2);
  endtask

  initial begin
    rst_n  = 1'b0;
    in_vld = 1'b1;
    a      = '1;
    b      = '1;
    for (int k = 0; k < 32; k++) begin
      rv[k] = 1'b0;
      rs[k] = '0;
      rt[k] = 0;
    end
    // R6: reset holds the outputs at zero while inputs toggle
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R6", {{W{1'b0}}, out_vld}, '0);
      chk("R6", sum, '0);
      a = a + 8'd29;
      b = b ^ 8'h5a;
    end
    @(negedge clk);
    rst_n  = 1'b1;
    in_vld = 1'b0;
    rv[0]  = 1'b0;
    cyc    = 1;

    // R2, R4: sparse valid pattern with bubbles
    for (int k = 0; k < 64; k++)
      step((k % 3 == 0) || (k % 7 == 2), W'(k * 37), W'(k * 11 + 3), 1);

    // R1, R3: every operand pair, one per clock
    for (int x = 0; x < (1 << W); x++)
      for (int y = 0; y < (1 << W); y++)
        step(1'b1, W'(x), W'(y), 0);

    // R5, R7: carry corners
    corner('1, W'(1));
    corner('1, '1);
    corner('0, '0);
    corner(W'(1) << (W - 1), W'(1) << (W - 1));
    corner({1'b0, {(W-1){1'b1}}}, W'(1));
    corner(W'(1), '1);
    corner('1, '0);

    for (int k = 0; k < LAT + 3; k++)
      step(1'b0, '0, '0, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 66000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule